// File: doc/BRIEF.md
# Accumulator Scale, Round and Clamp Unit

This block turns a packed accumulator of eight 24-bit lanes into eight unsigned bytes. Every lane is shifted right logically by an amount drawn from a byte-wide shift vector. The bits that fall off are used to round to nearest, and an exact half goes toward zero. The rounded value is then saturated to 0..255, and the eight bytes are packed into one 64-bit word.

A 4-bit select code picks where each lane's shift amount comes from. In broadcast mode a single element of the shift vector serves every lane. In lane-wise mode each lane takes the element with its own index. Only shifts of 0, 8 and 16 are legal. An unlisted select code or an illegal shift amount raises a flag and zeroes the lanes it affects. The result is captured in a register one cycle after the input strobe.

Top module: `acc_rsc_unit`

## Requirements
- R1: Lane i of the accumulator is `in_acc[24i+23:24i]`, and its byte result is `out_data[8i+7:8i]`. Shift-vector element k is `in_shv[8k+7:8k]`.
- R2: With a shift of 0 the lane value is not rounded. Any value above 255 gives 255, and any other value passes through unchanged.
- R3: With a shift s of 8 or 16 the result is floor(a / 2^s). It is incremented when the discarded remainder is greater than 2^(s-1).
- R4: A discarded remainder exactly equal to 2^(s-1) is a tie, and the kept value is not incremented.
- R5: After rounding, any value above 255, including one pushed there by the rounding increment, gives 255.
- R6: Select codes 4'b0000 to 4'b0111 give every lane shift-vector element k, where k = select[2:0]. The other elements have no effect.
- R7: Select code 4'b1011 gives lane i shift-vector element i.
- R8: Any other select code sets `out_illegal` and makes all eight result bytes zero.
- R9: A lane whose shift amount is not 0, 8 or 16 has a zero result byte and sets `out_illegal`. The other lanes are computed normally. With legal operands `out_illegal` is 0.
- R10: `out_valid` is `in_valid` delayed by one cycle. `out_data` and `out_illegal` load only in cycles where `in_valid` is high and hold their values otherwise.
- R11: While `rst_n` is low at a clock edge, `out_valid`, `out_data` and `out_illegal` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_acc | input | 192 | Eight 24-bit accumulator lanes |
| in_shv | input | 64 | Eight shift-amount bytes |
| in_sel | input | 4 | Shift source select code |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Eight saturated result bytes |
| out_illegal | output | 1 | Illegal select or shift amount seen |

## Verification
The bench sweeps every discarded-byte pattern under every kept value near the clamp point for shift 8, including the tie pattern 0x80. A design that rounds ties up or to even shows up there as results that are one too high. For shift 16 it places remainders just below the half, exactly on it and just above it under every kept byte. This exposes a missing carry into saturation at 255, and an arithmetic shift in place of a logical one would corrupt the upper lanes. It drives illegal shift amounts into unused broadcast elements and into individual lanes, and it walks all sixteen select codes. A wrong index mapping, leakage between lanes or a flag missed on a bad code therefore shows as a miscompare. Idle cycles after a result check that a design which reloads without the strobe is caught.

// File: rtl/acc_rsc_pkg.sv
package acc_rsc_pkg;

  typedef enum logic [1:0] {
    MODE_BCAST = 2'd0,
    MODE_LANE  = 2'd1,
    MODE_BAD   = 2'd2
  } shmode_e;

  localparam logic [3:0] SEL_LANEWISE = 4'b1011;

  // Broadcast codes have the top bit clear; one extra code means lane-wise.
  function automatic shmode_e decode_sel(input logic [3:0] sel);
    if (!sel[3])                   return MODE_BCAST;
    else if (sel == SEL_LANEWISE)  return MODE_LANE;
    else                           return MODE_BAD;
  endfunction

endpackage

// File: rtl/acc_rsc_shsel.sv
module acc_rsc_shsel
  import acc_rsc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SHV_W = 8
) (
  input  logic [LANES-1:0][SHV_W-1:0] shv,
  input  logic [3:0]                  sel,
  output logic [LANES-1:0][SHV_W-1:0] lane_shift,
  output logic                        sel_bad
);
  localparam int IDX_W = $clog2(LANES);

  shmode_e          mode;
  logic [SHV_W-1:0] bcast_amt;

  assign mode      = decode_sel(sel);
  assign sel_bad   = (mode == MODE_BAD);
  assign bcast_amt = shv[sel[IDX_W-1:0]];

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    always_comb begin
      unique case (mode)
        MODE_BCAST: lane_shift[g] = bcast_amt;
        MODE_LANE:  lane_shift[g] = shv[g];
        default:    lane_shift[g] = '0;
      endcase
    end
  end

endmodule

// File: rtl/acc_rsc_lane.sv
module acc_rsc_lane #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 8,
  parameter int SHV_W = 8
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SHV_W-1:0] shamt,
  output logic [OUT_W-1:0] res,
  output logic             bad,
  output logic             rnd_up,
  output logic             sat
);
  localparam logic [SHV_W-1:0] SH_NONE = '0;
  localparam logic [SHV_W-1:0] SH_MID  = SHV_W'(OUT_W);
  localparam logic [SHV_W-1:0] SH_HI   = SHV_W'(2 * OUT_W);
  localparam logic [ACC_W:0]   OUT_MAX = (ACC_W+1)'((1 << OUT_W) - 1);

  function automatic logic amt_legal(input logic [SHV_W-1:0] s);
    return (s == SH_NONE) || (s == SH_MID) || (s == SH_HI);
  endfunction

  function automatic logic [ACC_W-1:0] kept_field(input logic [ACC_W-1:0] a,
                                                  input logic [SHV_W-1:0] s);
    return a >> s;
  endfunction

  // First discarded bit below the kept field.
  function automatic logic half_bit(input logic [ACC_W-1:0] a,
                                    input logic [SHV_W-1:0] s);
    if (s == SH_NONE) return 1'b0;
    return |((a >> (s - SHV_W'(1))) & ACC_W'(1));
  endfunction

  // OR of every discarded bit under the half bit.
  function automatic logic sticky_bits(input logic [ACC_W-1:0] a,
                                       input logic [SHV_W-1:0] s);
    logic [ACC_W-1:0] mask;
    if (s == SH_NONE) return 1'b0;
    mask = (ACC_W'(1) << (s - SHV_W'(1))) - ACC_W'(1);
    return |(a & mask);
  endfunction

  logic [ACC_W-1:0] kept;
  logic             half, sticky;
  logic [ACC_W:0]   rounded;

  assign kept    = kept_field(acc, shamt);
  assign half    = half_bit(acc, shamt);
  assign sticky  = sticky_bits(acc, shamt);
  assign bad     = !amt_legal(shamt);
  // A tie (half set, nothing below) stays put: rounds toward zero.
  assign rnd_up  = half & sticky;
  assign rounded = {1'b0, kept} + {{ACC_W{1'b0}}, rnd_up};
  assign sat     = (rounded > OUT_MAX);
  assign res     = bad ? '0 : (sat ? '1 : rounded[OUT_W-1:0]);

endmodule

// File: rtl/acc_rsc_unit.sv
module acc_rsc_unit #(
  parameter int LANES = 8,
  parameter int ACC_W = 24,
  parameter int OUT_W = 8,
  parameter int SHV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*ACC_W-1:0] in_acc,
  input  logic [LANES*SHV_W-1:0] in_shv,
  input  logic [3:0]             in_sel,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_data,
  output logic                   out_illegal
);
  localparam int DATA_W = LANES * OUT_W;

  logic [LANES-1:0][SHV_W-1:0] shv_arr;
  logic [LANES-1:0][SHV_W-1:0] lane_shift;
  logic                        sel_bad;
  logic [LANES-1:0]            lane_bad;
  logic [LANES-1:0]            lane_rnd_up;
  logic [LANES-1:0]            lane_sat;
  logic [DATA_W-1:0]           next_data;
  logic                        any_bad;

  assign shv_arr = in_shv;

  acc_rsc_shsel #(.LANES(LANES), .SHV_W(SHV_W)) u_shsel (
    .shv        (shv_arr),
    .sel        (in_sel),
    .lane_shift (lane_shift),
    .sel_bad    (sel_bad)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OUT_W-1:0] res;
    acc_rsc_lane #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHV_W(SHV_W)) u_lane (
      .acc    (in_acc[g*ACC_W +: ACC_W]),
      .shamt  (lane_shift[g]),
      .res    (res),
      .bad    (lane_bad[g]),
      .rnd_up (lane_rnd_up[g]),
      .sat    (lane_sat[g])
    );
    assign next_data[g*OUT_W +: OUT_W] = sel_bad ? '0 : res;
  end

  assign any_bad = sel_bad | (|lane_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= next_data;
        out_illegal <= any_bad;
      end
    end
  end

endmodule

// File: rtl/acc_rsc_chk.sv
module acc_rsc_chk #(
  parameter int LANES = 8,
  parameter int OUT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   sel_bad,
  input logic [LANES-1:0]       lane_bad,
  input logic [LANES-1:0]       lane_rnd_up,
  input logic [LANES-1:0]       lane_sat,
  input logic                   out_valid,
  input logic [LANES*OUT_W-1:0] out_data,
  input logic                   out_illegal
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));

  a_r8_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_bad) |=> (out_illegal && (out_data == '0)));

  a_r9_flag_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sel_bad && (lane_bad == '0)) |=> !out_illegal);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r9_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_bad[g]) |=> (out_data[g*OUT_W +: OUT_W] == '0));

    a_r5_sat_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sel_bad && !lane_bad[g] && lane_sat[g])
        |=> (out_data[g*OUT_W +: OUT_W] == '1));

    a_r3_round_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sel_bad && !lane_bad[g] && lane_rnd_up[g])
        |=> (out_data[g*OUT_W +: OUT_W] != '0));
  end

endmodule

bind acc_rsc_unit acc_rsc_chk #(.LANES(LANES), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .sel_bad     (sel_bad),
  .lane_bad    (lane_bad),
  .lane_rnd_up (lane_rnd_up),
  .lane_sat    (lane_sat),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/acc_rsc_unit_bench.sv
module acc_rsc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int ACC_W = 24;
  localparam int MAX_CYC = 150000;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic [LANES*ACC_W-1:0] in_acc = '0;
  logic [LANES*8-1:0]     in_shv = '0;
  logic [3:0]             in_sel = '0;
  logic                   out_valid;
  logic [LANES*8-1:0]     out_data;
  logic                   out_illegal;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [63:0] last_d;
  logic        last_i;

  acc_rsc_unit u_acc_rsc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .in_shv(in_shv), .in_sel(in_sel), .out_valid(out_valid),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual hung at cycle %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Arithmetic model: quotient/remainder, strict-greater-than-half rounds up.
  function automatic int ref_lane(input int a, input int s, output bit bad);
    int q, r, d;
    bad = 1'b0;
    if (s == 0) q = a;
    else if (s == 8 || s == 16) begin
      d = 1 << s;
      q = a / d;
      r = a % d;
      if (2 * r > d) q = q + 1;
    end else begin
      bad = 1'b1;
      return 0;
    end
    return (q > 255) ? 255 : q;
  endfunction

  task automatic check_out(input string tag, input logic [63:0] ed,
                           input logic ei, input logic ev);
    n_vec++;
    if (out_data !== ed || out_illegal !== ei || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: actual data=%h ill=%b v=%b expected data=%h ill=%b v=%b",
               tag, out_data, out_illegal, out_valid, ed, ei, ev);
    end
  endtask

  task automatic apply(input logic [LANES*ACC_W-1:0] acc, input logic [63:0] shv,
                       input logic [3:0] sel, input string tag);
    logic [63:0] ed;
    logic        ei;
    ed = '0;
    ei = 1'b0;
    if (sel[3] && sel != 4'b1011) ei = 1'b1;
    else begin
      for (int i = 0; i < LANES; i++) begin
        int s;
        bit b;
        int v;
        s = (sel == 4'b1011) ? int'(shv[i*8 +: 8]) : int'(shv[int'(sel[2:0])*8 +: 8]);
        v = ref_lane(int'(acc[i*ACC_W +: ACC_W]), s, b);
        ed[i*8 +: 8] = 8'(v);
        if (b) ei = 1'b1;
      end
    end
    in_acc = acc; in_shv = shv; in_sel = sel; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_out(tag, ed, ei, 1'b1);
    last_d = ed;
    last_i = ei;
  endtask

  initial begin
    logic [LANES*ACC_W-1:0] acc;
    logic [63:0] shv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R11 reset state", 64'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R3/R4/R5/R6: shift 8 broadcast, every discarded byte under kept 0..259
    for (int hi = 0; hi < 260; hi++) begin
      for (int j = 0; j < 32; j++) begin
        int k;
        k = (hi + j) % 8;
        shv = {8{8'd3}};
        shv[k*8 +: 8] = 8'd8;
        for (int i = 0; i < LANES; i++)
          acc[i*ACC_W +: ACC_W] = ACC_W'((hi << 8) | (j * 8 + i));
        apply(acc, shv, 4'(k), "R3/R4/R5/R6 shift8 broadcast");
      end
    end

    // R1/R4/R5/R7: shift 16 lane-wise, remainders around the half
    for (int hi = 0; hi < 256; hi++) begin
      for (int j = 0; j < 32; j++) begin
        for (int i = 0; i < LANES; i++)
          acc[i*ACC_W +: ACC_W] = ACC_W'((hi << 16) | ((j * 8 + i) << 8) | ((hi % 2) ? 255 : 0));
        apply(acc, {8{8'd16}}, 4'b1011, "R1/R4/R5/R7 shift16 lanewise");
      end
    end

    // R2: shift 0, mixed magnitudes
    for (int n = 0; n < 2000; n++) begin
      for (int i = 0; i < LANES; i++) begin
        seed = lcg(seed);
        case ((n + i) % 3)
          0: acc[i*ACC_W +: ACC_W] = seed[ACC_W-1:0];
          1: acc[i*ACC_W +: ACC_W] = ACC_W'(seed[8:0]);
          default: acc[i*ACC_W +: ACC_W] = ACC_W'(seed[7:0]);
        endcase
      end
      shv = {8{8'd16}};
      shv[(n % 8)*8 +: 8] = 8'd0;
      apply(acc, shv, 4'(n % 8), "R2 shift0 clamp");
    end

    // R9: lane-wise with some illegal shift amounts
    for (int n = 0; n < 2000; n++) begin
      for (int i = 0; i < LANES; i++) begin
        seed = lcg(seed);
        acc[i*ACC_W +: ACC_W] = seed[ACC_W-1:0];
        seed = lcg(seed);
        case (seed[25:24])
          2'd0: shv[i*8 +: 8] = 8'd0;
          2'd1: shv[i*8 +: 8] = 8'd8;
          2'd2: shv[i*8 +: 8] = 8'd16;
          default: shv[i*8 +: 8] = seed[7:0];
        endcase
      end
      apply(acc, shv, 4'b1011, "R9 lanewise mixed legality");
    end

    // R6/R7/R8: every select code
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < LANES; i++)
        acc[i*ACC_W +: ACC_W] = ACC_W'(24'h01_80_00 + i * 24'h00_40_41);
      apply(acc, {8'd8, 8'd16, 8'd0, 8'd8, 8'd16, 8'd0, 8'd8, 8'd16},
            4'(c), "R6/R7/R8 select sweep");
    end

    // R10: idle cycles hold the result and drop valid
    in_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      in_acc = ~in_acc; in_sel = 4'b1111; in_shv = ~in_shv;
      @(posedge clk);
      @(negedge clk);
      check_out("R10 hold without strobe", last_d, last_i, 1'b0);
    end

    // R11: reset after activity
    apply({LANES{24'hFF_FFFF}}, {8{8'd0}}, 4'd0, "R2 saturate all");
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_out("R11 reset clears", 64'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule